// File: doc/BRIEF.md
# Half-Stochastic LDPC Variable Node

This block is one variable node of an LDPC decoder that moves messages between nodes as random bit streams but does its own arithmetic on log-likelihood ratios (LLRs). Each clock it takes a signed channel LLR, one fixed-point LLR estimate per attached edge, and one random number that is already in the LLR domain. The edge estimates come from per-edge trackers that sit outside the block.

The node first reduces each edge estimate to the working LLR width. It then forms the total of the channel LLR and all edge LLRs. For every edge it also forms the extrinsic sum, which leaves out that edge's own input. Each extrinsic sum is clipped to the working width and compared with the shared random LLR, and the result is that edge's next stream bit. The sign of the total gives the hard decision on the codeword bit. The outputs are registered, so they appear one cycle after the inputs.

Top module: `stoch_var_node`

## Requirements
- R1: While `rst_n` is low at a rising edge, every bit of `edge_bit` and `hard_bit` is 0 after that edge.
- R2: Each edge estimate is a TRK_W-bit two's-complement number with TRK_FRAC fractional bits. It is reduced to the working width by an arithmetic shift right by TRK_FRAC (rounding toward minus infinity) and then clipped to [-2^(LLR_W-1), 2^(LLR_W-1)-1]. With the defaults this is a floor divide by 64, clipped to [-16, 15].
- R3: The extrinsic sum for edge j is the channel LLR plus every reduced edge LLR except edge j. It is computed at full precision with no wrap-around.
- R4: Before the comparison, each extrinsic sum is clipped to [-2^(LLR_W-1), 2^(LLR_W-1)-1].
- R5: Bit j of `edge_bit` is 1 exactly when the signed `rnd_llr` is strictly greater than the clipped extrinsic sum of edge j. When the two are equal, the bit is 0.
- R6: `hard_bit` is 1 exactly when the full-precision total (channel plus all reduced edge LLRs) is below zero. A total of zero gives 0.
- R7: Outputs change only at a rising edge. After reset is released, they reflect the inputs sampled at the previous rising edge.
- R8: One `rnd_llr` value serves all DV comparisons in a cycle. Edges whose clipped extrinsic sums are equal therefore receive equal bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_llr | input | LLR_W | Signed channel LLR |
| trk_llr | input | DV*TRK_W | Signed fixed-point edge estimates; edge k occupies bits [k*TRK_W +: TRK_W] |
| rnd_llr | input | LLR_W | Signed random number in the LLR domain, shared by all edges |
| edge_bit | output | DV | Registered stochastic output bit per edge |
| hard_bit | output | 1 | Registered hard decision (1 when the total is negative) |

## Verification
Two things happen on the same clock edge: every edge bit is produced from its own extrinsic sum, and the hard decision is produced from the total sum of the same input set. A wrong width or a wrong exclusion in the adders can therefore show up in one output and not the other. The bench drives input sets where the total lies far outside the working range but each extrinsic sum clips, and sets where one small negative estimate changes some extrinsic comparisons but not the total's sign. On every clock, a behavioural model that uses plain integers judges both outputs together.

// File: rtl/rhs_vn_pkg.sv
package rhs_vn_pkg;
    localparam int DEF_DV       = 6;
    localparam int DEF_LLR_W    = 5;
    localparam int DEF_TRK_W    = 12;
    localparam int DEF_TRK_FRAC = 6;

    function automatic int sat_int(input int v, input int lo, input int hi);
        if (v > hi)
            return hi;
        else if (v < lo)
            return lo;
        else
            return v;
    endfunction
endpackage

// File: rtl/llr_narrow.sv
module llr_narrow
    import rhs_vn_pkg::*;
#(
    parameter int TRK_W    = DEF_TRK_W,
    parameter int TRK_FRAC = DEF_TRK_FRAC,
    parameter int LLR_W    = DEF_LLR_W
) (
    input  logic signed [TRK_W-1:0] trk_i,
    output logic signed [LLR_W-1:0] llr_o
);
    localparam int INT_W = TRK_W - TRK_FRAC;
    localparam int LO    = -(2 ** (LLR_W - 1));
    localparam int HI    = (2 ** (LLR_W - 1)) - 1;

    generate
        if (INT_W <= LLR_W) begin : g_fits
            always_comb begin
                int v;
                v     = int'(trk_i) >>> TRK_FRAC;
                llr_o = LLR_W'(v);
            end
        end else begin : g_clip
            always_comb begin
                int v;
                v     = int'(trk_i) >>> TRK_FRAC;
                llr_o = LLR_W'(sat_int(v, LO, HI));
            end
        end
    endgenerate
endmodule

// File: rtl/vn_sum.sv
module vn_sum
    import rhs_vn_pkg::*;
#(
    parameter int DV    = DEF_DV,
    parameter int LLR_W = DEF_LLR_W,
    parameter int SUM_W = DEF_LLR_W + $clog2(DEF_DV + 1)
) (
    input  logic signed [LLR_W-1:0] chan_i,
    input  logic signed [LLR_W-1:0] edge_i [DV],
    output logic signed [SUM_W-1:0] tot_o,
    output logic signed [SUM_W-1:0] ext_o  [DV]
);
    localparam int EXT_W = SUM_W - LLR_W;

    logic signed [SUM_W-1:0] chan_x;
    logic signed [SUM_W-1:0] edge_x [DV];

    always_comb begin
        chan_x = {{EXT_W{chan_i[LLR_W-1]}}, chan_i};
        for (int k = 0; k < DV; k++)
            edge_x[k] = {{EXT_W{edge_i[k][LLR_W-1]}}, edge_i[k]};
    end

    always_comb begin
        tot_o = chan_x;
        for (int k = 0; k < DV; k++)
            tot_o = tot_o + edge_x[k];
    end

    always_comb begin
        for (int j = 0; j < DV; j++) begin
            ext_o[j] = chan_x;
            for (int k = 0; k < DV; k++)
                if (k != j)
                    ext_o[j] = ext_o[j] + edge_x[k];
        end
    end
endmodule

// File: rtl/stoch_cmp.sv
module stoch_cmp
    import rhs_vn_pkg::*;
#(
    parameter int DV    = DEF_DV,
    parameter int LLR_W = DEF_LLR_W,
    parameter int SUM_W = DEF_LLR_W + $clog2(DEF_DV + 1)
) (
    input  logic signed [SUM_W-1:0] ext_i     [DV],
    input  logic signed [LLR_W-1:0] rnd_i,
    output logic signed [LLR_W-1:0] ext_sat_o [DV],
    output logic        [DV-1:0]    bit_o
);
    localparam int LO = -(2 ** (LLR_W - 1));
    localparam int HI = (2 ** (LLR_W - 1)) - 1;

    always_comb begin
        for (int j = 0; j < DV; j++) begin
            ext_sat_o[j] = LLR_W'(sat_int(int'(ext_i[j]), LO, HI));
            bit_o[j]     = (rnd_i > ext_sat_o[j]);
        end
    end
endmodule

// File: rtl/stoch_var_node.sv
module stoch_var_node
    import rhs_vn_pkg::*;
#(
    parameter int DV       = DEF_DV,
    parameter int LLR_W    = DEF_LLR_W,
    parameter int TRK_W    = DEF_TRK_W,
    parameter int TRK_FRAC = DEF_TRK_FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LLR_W-1:0]        chan_llr,
    input  logic [DV*TRK_W-1:0]     trk_llr,
    input  logic [LLR_W-1:0]        rnd_llr,
    output logic [DV-1:0]           edge_bit,
    output logic                    hard_bit
);
    localparam int SUM_W = LLR_W + $clog2(DV + 1);

    typedef struct packed {
        logic [DV-1:0] bits;
        logic          hard;
    } vn_state_t;

    vn_state_t st_d, st_q;

    logic signed [LLR_W-1:0] narrow_w  [DV];
    logic signed [SUM_W-1:0] ext_w     [DV];
    logic signed [LLR_W-1:0] ext_sat_w [DV];
    logic signed [SUM_W-1:0] tot_w;
    logic        [DV-1:0]    cmp_bits_w;

    generate
        for (genvar k = 0; k < DV; k++) begin : g_edge
            llr_narrow #(
                .TRK_W   (TRK_W),
                .TRK_FRAC(TRK_FRAC),
                .LLR_W   (LLR_W)
            ) i_narrow (
                .trk_i(trk_llr[k*TRK_W +: TRK_W]),
                .llr_o(narrow_w[k])
            );
        end
    endgenerate

    vn_sum #(
        .DV   (DV),
        .LLR_W(LLR_W),
        .SUM_W(SUM_W)
    ) i_sum (
        .chan_i(chan_llr),
        .edge_i(narrow_w),
        .tot_o (tot_w),
        .ext_o (ext_w)
    );

    stoch_cmp #(
        .DV   (DV),
        .LLR_W(LLR_W),
        .SUM_W(SUM_W)
    ) i_cmp (
        .ext_i    (ext_w),
        .rnd_i    (rnd_llr),
        .ext_sat_o(ext_sat_w),
        .bit_o    (cmp_bits_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.bits = cmp_bits_w;
        st_d.hard = tot_w[SUM_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign edge_bit = st_q.bits;
    assign hard_bit = st_q.hard;

    generate
        for (genvar j = 0; j < DV; j++) begin : g_chk
            AST_NEG_EST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
                $signed(trk_llr[j*TRK_W +: TRK_W]) < 0 |-> narrow_w[j] < 0); // R2
            AST_EXT_EXCLUDES_OWN: assert property (@(posedge clk) disable iff (!rst_n)
                ext_w[j] == SUM_W'(tot_w - SUM_W'(narrow_w[j]))); // R3
            AST_TIE_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                $signed(rnd_llr) == ext_sat_w[j] |=> !edge_bit[j]); // R5
        end
    endgenerate

    AST_HARD_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        tot_w < 0 |=> hard_bit); // R6
    AST_HARD_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        tot_w >= 0 |=> !hard_bit); // R6
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $stable(chan_llr) && $stable(trk_llr) && $stable(rnd_llr)
        |=> $stable(edge_bit) && $stable(hard_bit)); // R7
endmodule

// File: tb/test_stoch_var_node.sv
module test_stoch_var_node;
    localparam int DV    = 6;
    localparam int LW    = 5;
    localparam int TW    = 12;
    localparam int FRAC  = 6;
    localparam int LO    = -16;
    localparam int HI    = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LW-1:0]     chan_llr = '0;
    logic [DV*TW-1:0]  trk_llr = '0;
    logic [LW-1:0]     rnd_llr = '0;
    logic [DV-1:0]     edge_bit;
    logic              hard_bit;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit have_exp = 0;
    logic [DV-1:0] exp_bits;
    logic          exp_hard;
    string         exp_tag;

    always #2 clk = ~clk;

    stoch_var_node #(.DV(DV), .LLR_W(LW), .TRK_W(TW), .TRK_FRAC(FRAC)) i_stoch_var_node (
        .clk(clk), .rst_n(rst_n), .chan_llr(chan_llr), .trk_llr(trk_llr),
        .rnd_llr(rnd_llr), .edge_bit(edge_bit), .hard_bit(hard_bit)
    );

    function automatic int clip(input int v);
        return (v > HI) ? HI : ((v < LO) ? LO : v);
    endfunction

    task automatic check_now();
        checks++;
        if (edge_bit !== exp_bits) begin
            errors++;
            $display("FAIL %s edge_bit: actual=%b expected=%b", exp_tag, edge_bit, exp_bits);
        end
        checks++;
        if (hard_bit !== exp_hard) begin
            errors++;
            $display("FAIL %s hard_bit: actual=%b expected=%b", exp_tag, hard_bit, exp_hard);
        end
    endtask

    task automatic step(input int c, input int t[DV], input int r, input string tag);
        int n[DV];
        int tot;
        @(negedge clk);
        if (have_exp) check_now();
        chan_llr = LW'(c);
        rnd_llr  = LW'(r);
        tot = c;
        for (int k = 0; k < DV; k++) begin
            trk_llr[k*TW +: TW] = TW'(t[k]);
            n[k] = clip(t[k] >>> FRAC);
            tot += n[k];
        end
        for (int j = 0; j < DV; j++)
            exp_bits[j] = (r > clip(tot - n[j]));
        exp_hard = (tot < 0);
        exp_tag  = tag;
        have_exp = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int z[DV];
        int t[DV];
        for (int k = 0; k < DV; k++) z[k] = 0;
        repeat (3) @(negedge clk);
        chan_llr = 5'h0b; rnd_llr = 5'h07; trk_llr = '1;
        @(negedge clk);
        exp_bits = '0; exp_hard = 0; exp_tag = "R1 reset";
        check_now();
        @(negedge clk);
        rst_n = 1'b1;
        // R5 R6: all zero, ties everywhere, total zero
        step(0, z, 0, "R5 R6 zero tie");
        step(0, z, 1, "R5 R8 rnd above all");
        // R2 clip of large positive estimate, R4 extrinsic clip, R5 tie at top
        for (int k = 0; k < DV; k++) t[k] = 2047;
        step(0, t, 15, "R2 R4 R5 top tie");
        step(0, t, -16, "R2 R4 low rnd");
        // R3 no wrap: total 105 positive
        for (int k = 0; k < DV; k++) t[k] = 15 * 64;
        step(15, t, 14, "R3 R6 no wrap pos");
        // large negative: total -112
        for (int k = 0; k < DV; k++) t[k] = -2048;
        step(-16, t, -16, "R2 R3 R4 R6 neg clip tie");
        step(-16, t, -15, "R4 R5 R8 neg above");
        // R2 floor of small negative fraction
        t = z; t[2] = -1;
        step(0, t, -1, "R2 floor tie");
        step(0, t, 0, "R2 R5 floor");
        // R2 positive fraction truncates to zero
        t = z; t[4] = 63;
        step(0, t, 0, "R2 pos trunc");
        // R7 held inputs
        step(0, t, 0, "R7 hold");
        // random sweep, compared every clock
        for (int i = 0; i < 400; i++) begin
            int rt[DV];
            for (int k = 0; k < DV; k++) rt[k] = int'($urandom_range(0, 4095)) - 2048;
            if (i % 3 == 0)
                for (int k = 0; k < DV; k++) rt[k] = rt[k] >>> 3;
            step(int'($urandom_range(0, 31)) - 16, rt, int'($urandom_range(0, 31)) - 16,
                 "R3 R4 R5 R6 R7 R8 random");
        end
        @(negedge clk);
        check_now();
        // R1 reset during operation
        rst_n = 1'b0;
        @(negedge clk);
        exp_bits = '0; exp_hard = 0; exp_tag = "R1 mid reset";
        check_now();
        finish_run();
    end
endmodule